// File: doc/BRIEF.md
# External Bus Address Output Controller

This block sits at the edge of a small microcontroller bus interface. It drives the external address pins and the active-low read strobe. A requester presents one bus cycle at a time. Each request carries an address, a write flag and a flag that marks the target as external or on-chip. External targets get a three-state basic cycle. On-chip targets complete internally in one state. A one-clock ready pulse marks the final state of every cycle.

A single control bit sets how the external address pins are refreshed. In the default setting the pins take the new address at the start of every bus cycle, whatever the target. In the hold setting the pins change only when an external cycle starts. The address of an external read therefore stays on the pins through any following on-chip cycles. This gives an attached device address hold time after the read strobe rises.

Top module: `ext_addr_ctrl`

## Requirements
- R1: While reset is asserted and just after it, `ext_addr` is zero, `ext_rd_n` is 1, `req_ready` is 0 and `upd_mode` is 0 (refresh on every cycle).
- R2: A request with `req_ext`=1 accepted at an edge runs states T1, T2 and T3 in the next three clocks. `req_ready` is 1 only during T3.
- R3: In an external read (`req_write`=0), `ext_rd_n` is 1 in T1 and 0 in T2 and T3. It returns to 1 in the first clock after T3.
- R4: In an external write (`req_write`=1), `ext_rd_n` stays 1 for the whole cycle.
- R5: A request with `req_ext`=0 takes one state, with `req_ready`=1 in the clock after acceptance and `ext_rd_n` held at 1.
- R6: When `upd_mode`=0, `ext_addr` takes `req_addr` at the edge that accepts any request, so it is valid from T1 or from the single on-chip state.
- R7: When `upd_mode`=1, `ext_addr` takes `req_addr` only when an external request is accepted. On-chip cycles and idle clocks leave it unchanged.
- R8: A mode write takes effect from the next accepted request. If the write falls at the same edge as an acceptance, or anywhere inside a cycle, that cycle uses the old mode.
- R9: Requests are taken only when idle. A `req_valid` held high through a cycle gives exactly one ready pulse. No ready appears while `req_valid` is low.
- R10: A write with `cfg_we`=1 loads `cfg_upd_hold` into the mode bit, which shows on `upd_mode` from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus cycle request, held until ready |
| req_addr | input | ADDR_W | Address of the requested cycle |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_ext | input | 1 | 1 = external space, 0 = on-chip |
| req_ready | output | 1 | One-clock pulse in the final state of a cycle |
| cfg_we | input | 1 | Mode bit write enable |
| cfg_upd_hold | input | 1 | Mode value: 0 = refresh every cycle, 1 = refresh on external only |
| upd_mode | output | 1 | Current mode bit |
| ext_addr | output | ADDR_W | External address pins |
| ext_rd_n | output | 1 | External read strobe, active low |

## Verification
The assertions check on every cycle the state order T1→T2→T3, the position of the read strobe within a cycle, the single-clock ready pulse, and the address load rule for each mode at every acceptance and idle clock. Only the bench scenarios can show that an external read address survives a chain of several on-chip fetches. They also cover the old-mode rule when a mode write arrives inside a cycle or at the acceptance edge, and the match between ready pulses and the requests actually issued.

// File: rtl/eac_pkg.sv
package eac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_ON   = 3'd4
  } bus_st_e;

  typedef enum logic {
    UPD_EVERY    = 1'b0,
    UPD_EXT_ONLY = 1'b1
  } upd_mode_e;

  // Address pins reload when the cycle is external or the mode refreshes always
  function automatic logic addr_reload(upd_mode_e mode, logic is_ext);
    return is_ext || (mode == UPD_EVERY);
  endfunction

  function automatic bus_st_e st_advance(bus_st_e cur, logic start, logic is_ext);
    bus_st_e nxt;
    case (cur)
      ST_IDLE: nxt = start ? (is_ext ? ST_T1 : ST_ON) : ST_IDLE;
      ST_T1:   nxt = ST_T2;
      ST_T2:   nxt = ST_T3;
      ST_T3:   nxt = ST_IDLE;
      ST_ON:   nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
    return nxt;
  endfunction

  // Strobe is active in the second and third external states of a read
  function automatic logic strobe_active(bus_st_e cur, logic is_read);
    return is_read && ((cur == ST_T2) || (cur == ST_T3));
  endfunction

  function automatic logic is_final(bus_st_e cur);
    return (cur == ST_T3) || (cur == ST_ON);
  endfunction

endpackage

// File: rtl/eac_mode_reg.sv
module eac_mode_reg
  import eac_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      we,
  input  logic      wdata,
  output upd_mode_e mode
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= UPD_EVERY;
    end else if (we) begin
      mode <= upd_mode_e'(wdata);
    end
  end

endmodule

// File: rtl/eac_seq.sv
module eac_seq
  import eac_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    req_ext,
  input  logic    req_write,
  output logic    start,
  output bus_st_e state,
  output logic    cur_read,
  output logic    ready,
  output logic    rd_n
);

  assign start = (state == ST_IDLE) && req_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_read <= 1'b0;
    end else begin
      state <= st_advance(state, start, req_ext);
      if (start) begin
        cur_read <= !req_write;
      end
    end
  end

  assign ready = is_final(state);
  assign rd_n  = !strobe_active(state, cur_read);

endmodule

// File: rtl/eac_addr_out.sv
module eac_addr_out #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);

  localparam logic [ADDR_W-1:0] ADDR_RST = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_out <= ADDR_RST;
    end else if (load) begin
      addr_out <= addr_in;
    end
  end

endmodule

// File: rtl/ext_addr_ctrl.sv
module ext_addr_ctrl
  import eac_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_ext,
  output logic              req_ready,
  input  logic              cfg_we,
  input  logic              cfg_upd_hold,
  output logic              upd_mode,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              ext_rd_n
);

  upd_mode_e mode_q;
  bus_st_e   bus_st;
  logic      cyc_start;
  logic      cur_read;
  logic      addr_load;

  // Named events for the checker
  logic st_idle, st_t1, st_t2, st_t3;

  eac_mode_reg u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_upd_hold),
    .mode  (mode_q)
  );

  eac_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ext   (req_ext),
    .req_write (req_write),
    .start     (cyc_start),
    .state     (bus_st),
    .cur_read  (cur_read),
    .ready     (req_ready),
    .rd_n      (ext_rd_n)
  );

  // Mode sampled at acceptance, so a write in the same edge lands afterwards
  assign addr_load = cyc_start && addr_reload(mode_q, req_ext);

  eac_addr_out #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (addr_load),
    .addr_in  (req_addr),
    .addr_out (ext_addr)
  );

  assign upd_mode = mode_q;
  assign st_idle  = (bus_st == ST_IDLE);
  assign st_t1    = (bus_st == ST_T1);
  assign st_t2    = (bus_st == ST_T2);
  assign st_t3    = (bus_st == ST_T3);

endmodule

// File: rtl/eac_checker.sv
module eac_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ext,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_ready,
  input logic              cfg_we,
  input logic              cfg_upd_hold,
  input logic              upd_mode,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              ext_rd_n,
  input logic              cyc_start,
  input logic              cur_read,
  input logic              st_idle,
  input logic              st_t1,
  input logic              st_t2,
  input logic              st_t3
);

  a_r2_t1_to_t2: assert property (@(posedge clk) disable iff (!rst_n)
    st_t1 |=> st_t2);

  a_r2_t2_to_t3_ready: assert property (@(posedge clk) disable iff (!rst_n)
    st_t2 |=> (st_t3 && req_ready));

  a_r3_strobe_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_t2 || st_t3) && cur_read) |-> !ext_rd_n);

  a_r4_strobe_high_else: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_t2 || st_t3) |-> ext_rd_n);

  a_r9_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  a_r6_refresh_every: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !upd_mode) |=> (ext_addr == $past(req_addr)));

  a_r7_ext_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && req_ext) |=> (ext_addr == $past(req_addr)));

  a_r7_onchip_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !req_ext && upd_mode) |=> $stable(ext_addr));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && !cyc_start) |=> $stable(ext_addr));

  a_r10_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (upd_mode == $past(cfg_upd_hold)));

endmodule

bind ext_addr_ctrl eac_checker #(.ADDR_W(ADDR_W)) u_eac_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ext      (req_ext),
  .req_addr     (req_addr),
  .req_ready    (req_ready),
  .cfg_we       (cfg_we),
  .cfg_upd_hold (cfg_upd_hold),
  .upd_mode     (upd_mode),
  .ext_addr     (ext_addr),
  .ext_rd_n     (ext_rd_n),
  .cyc_start    (cyc_start),
  .cur_read     (cur_read),
  .st_idle      (st_idle),
  .st_t1        (st_t1),
  .st_t2        (st_t2),
  .st_t3        (st_t3)
);

// File: tb/ext_addr_ctrl_bench.sv
module ext_addr_ctrl_bench;

  localparam int ADDR_W = 24;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_write = 1'b0;
  logic              req_ext = 1'b0;
  logic              req_ready;
  logic              cfg_we = 1'b0;
  logic              cfg_upd_hold = 1'b0;
  logic              upd_mode;
  logic [ADDR_W-1:0] ext_addr;
  logic              ext_rd_n;

  int n_cmp = 0;
  int n_bad = 0;

  // Bench model of the pins
  logic              m_hold = 1'b0;
  logic [ADDR_W-1:0] m_addr = '0;
  logic [ADDR_W-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_addr_ctrl #(.ADDR_W(ADDR_W)) u_ext_addr_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_write    (req_write),
    .req_ext      (req_ext),
    .req_ready    (req_ready),
    .cfg_we       (cfg_we),
    .cfg_upd_hold (cfg_upd_hold),
    .upd_mode     (upd_mode),
    .ext_addr     (ext_addr),
    .ext_rd_n     (ext_rd_n)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: at each ready, compare the pins against the next expected item
  always @(negedge clk) begin
    if (rst_n && req_ready === 1'b1) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected ready", 64'(req_ready), 64'd0);
      end else begin
        logic [ADDR_W-1:0] e;
        e = exp_q.pop_front();
        check("R6/R7 ext_addr at ready", 64'(ext_addr), 64'(e));
      end
    end
  end

  task automatic write_mode(input logic v);
    cfg_we = 1'b1;
    cfg_upd_hold = v;
    @(negedge clk);
    cfg_we = 1'b0;
    m_hold = v;
    check("R10 upd_mode after write", 64'(upd_mode), 64'(v));
  endtask

  // Driver: cfg_at = 0 writes at the accepting edge, k writes after k clocks
  task automatic bus_cycle(input logic [ADDR_W-1:0] a, input logic wr, input logic ext,
                           input logic cfg_do, input logic cfg_v, input int cfg_at);
    int n;
    int final_n;
    logic exp_rdn;
    if (ext || !m_hold) m_addr = a;
    exp_q.push_back(m_addr);
    final_n = ext ? 3 : 1;
    req_valid = 1'b1;
    req_addr  = a;
    req_write = wr;
    req_ext   = ext;
    if (cfg_do && cfg_at == 0) begin
      cfg_we = 1'b1;
      cfg_upd_hold = cfg_v;
    end
    n = 0;
    while (n < 8) begin
      @(negedge clk);
      n++;
      cfg_we = 1'b0;
      exp_rdn = !(ext && !wr && n >= 2);
      check(ext ? (wr ? "R4 strobe in write" : "R3 strobe in read") : "R5 strobe on-chip",
            64'(ext_rd_n), 64'(exp_rdn));
      check(ext ? "R2 ready position" : "R5 ready position",
            64'(req_ready), 64'(n == final_n));
      if (cfg_do && cfg_at == n) begin
        cfg_we = 1'b1;
        cfg_upd_hold = cfg_v;
      end
      if (n == final_n) break;
    end
    req_valid = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0;
    if (cfg_do) m_hold = cfg_v;
    check("R3 strobe released after cycle", 64'(ext_rd_n), 64'd1);
    check("R9 no ready when idle", 64'(req_ready), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ext_addr in reset", 64'(ext_addr), 64'd0);
    check("R1 rd_n in reset", 64'(ext_rd_n), 64'd1);
    check("R1 ready in reset", 64'(req_ready), 64'd0);
    check("R1 mode in reset", 64'(upd_mode), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ext_addr after reset", 64'(ext_addr), 64'd0);

    // R6: refresh on every cycle
    bus_cycle(24'h123456, 1'b0, 1'b1, 1'b0, 1'b0, 0);
    bus_cycle(24'h000100, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    bus_cycle(24'hABCDEF, 1'b1, 1'b1, 1'b0, 1'b0, 0);
    bus_cycle(24'h000200, 1'b1, 1'b0, 1'b0, 1'b0, 0);
    check("R6 on-chip refresh", 64'(ext_addr), 64'h000200);

    // R7: hold across on-chip cycles
    write_mode(1'b1);
    bus_cycle(24'h55AA33, 1'b0, 1'b1, 1'b0, 1'b0, 0);
    bus_cycle(24'h000300, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    bus_cycle(24'h000304, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    bus_cycle(24'h000308, 1'b1, 1'b0, 1'b0, 1'b0, 0);
    check("R7 read address held", 64'(ext_addr), 64'h55AA33);
    bus_cycle(24'h0F0F0F, 1'b1, 1'b1, 1'b0, 1'b0, 0);
    bus_cycle(24'h000010, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    check("R7 write address held", 64'(ext_addr), 64'h0F0F0F);

    // R8: mode write inside an external cycle, then at an acceptance edge
    bus_cycle(24'h111111, 1'b0, 1'b1, 1'b1, 1'b0, 2);
    check("R10 mode cleared", 64'(upd_mode), 64'd0);
    bus_cycle(24'h222222, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    check("R8 new mode from next cycle", 64'(ext_addr), 64'h222222);
    bus_cycle(24'h333333, 1'b0, 1'b0, 1'b1, 1'b1, 0);
    check("R8 old mode at same edge", 64'(ext_addr), 64'h333333);
    bus_cycle(24'h444444, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    check("R8 hold after concurrent write", 64'(ext_addr), 64'h333333);

    // R9: idle clocks give no ready and leave the pins alone
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9 idle no ready", 64'(req_ready), 64'd0);
      check("R7 idle address stable", 64'(ext_addr), 64'h333333);
    end
    check("R9 every request answered", 64'(exp_q.size()), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule